// File: doc/BRIEF.md
# Hybrid Ternary/Binary Resistor-Ladder DAC Pin Encoder

This block turns an unsigned level code into the drive controls for a small resistor-ladder DAC built from general-purpose pins. The lowest pins work in base three. Each of them can be pulled low, pushed high, or released, and a released pin settles at the mid rail through an external divider. The upper one or two pins are plain binary outputs. With three ternary pins and two binary pins the ladder reaches 3·3·3·2·2 = 108 distinct levels. With one binary pin it reaches 54.

A load strobe starts a conversion. The block clamps the code to the highest valid level. It then extracts one digit per clock by repeated division: base 3 for the ternary positions and base 2 for the binary ones. The pins change only when the last digit is known, so no half-built code ever reaches the ladder. A one-cycle done pulse marks that moment. A busy flag tells the caller when a new load would be ignored.

Top module: `hdac_encoder`

## Requirements
- R1: While reset is asserted and after its release, every pin has output enable 1 and data 0, and busy and done are 0.
- R2: Ternary pin j (j = 0 for the least significant) carries base-3 digit j of the clamped level. Digit 0 gives enable 1 and data 0. Digit 1 gives enable 0 and data 0, which is released. Digit 2 gives enable 1 and data 1.
- R3: Binary pin b sits at pin index TERN_PINS+b. Its data is bit b of (clamped level / 3^TERN_PINS), and its enable is 1.
- R4: The binary pins never have output enable 0.
- R5: A level of 3^TERN_PINS·2^BIN_PINS (108 by default) or above is treated as 107, which gives all pins driven high.
- R6: A load is accepted only in a cycle where busy is 0. From the next cycle, busy is 1 for TERN_PINS+BIN_PINS cycles (5 by default). In the cycle after that, busy is 0 and done is 1 for exactly one cycle, and the new pin values appear in that same cycle.
- R7: A load presented while busy is 1 has no effect on the conversion in progress or on the pins, and it starts no later conversion.
- R8: The pin outputs change only in a cycle where done is 1.
- R9: A pin whose output enable is 0 always has data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Start a conversion of level_i (ignored while busy) |
| level_i | input | LEVEL_W (7) | Unsigned level code |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the pins take the new code |
| pin_oe_o | output | TERN_PINS+BIN_PINS (5) | Per-pin output enable (0 = released) |
| pin_dat_o | output | TERN_PINS+BIN_PINS (5) | Per-pin drive value |

## Verification
A corrupted remainder or digit index shows up as a wrong pin pattern in the done cycle of that conversion. That is at most six cycles after the load, and the reference model compares the pins on every clock. A broken busy or done sequence shows up in the first cycle where it differs, because both flags are compared every cycle. A leak of the work register into the pins shows up as a change in a cycle without done. Three kinds of input press on the state: loads held high across busy, loads at the clamp boundary, and a sweep of all codes.

// File: rtl/hdac_pkg.sv
package hdac_pkg;

    typedef enum logic [1:0] {
        TDIG_LOW  = 2'd0,
        TDIG_MID  = 2'd1,
        TDIG_HIGH = 2'd2
    } tdig_e;

    function automatic int level_count(input int tern_pins, input int bin_pins);
        int acc;
        acc = 1;
        for (int i = 0; i < tern_pins; i++) acc = acc * 3;
        for (int i = 0; i < bin_pins; i++) acc = acc * 2;
        return acc;
    endfunction

endpackage

// File: rtl/hdac_clamp.sv
module hdac_clamp #(
    parameter int LEVEL_W   = 7,
    parameter int TERN_PINS = 3,
    parameter int BIN_PINS  = 2
) (
    input  logic [LEVEL_W-1:0] level_i,
    output logic [LEVEL_W-1:0] level_o
);
    localparam int LEVELS = hdac_pkg::level_count(TERN_PINS, BIN_PINS);
    localparam logic [LEVEL_W-1:0] TOP_CODE = LEVEL_W'(LEVELS - 1);

    always_comb begin
        level_o = (level_i > TOP_CODE) ? TOP_CODE : level_i;
        assert (level_o <= TOP_CODE) else $error("assert_clamp_range_R5");
    end
endmodule

// File: rtl/hdac_digit_div.sv
module hdac_digit_div #(
    parameter int LEVEL_W = 7
) (
    input  logic [LEVEL_W-1:0] rem_i,
    input  logic               tern_i,
    output logic [LEVEL_W-1:0] quot_o,
    output logic [1:0]         digit_o
);
    always_comb begin
        if (tern_i) begin
            quot_o  = rem_i / LEVEL_W'(3);
            digit_o = 2'(rem_i % LEVEL_W'(3));
        end else begin
            quot_o  = rem_i >> 1;
            digit_o = {1'b0, rem_i[0]};
        end
    end
endmodule

// File: rtl/hdac_pin_map.sv
module hdac_pin_map #(
    parameter int TERN_PINS = 3,
    parameter int BIN_PINS  = 2,
    localparam int NPINS    = TERN_PINS + BIN_PINS
) (
    input  logic [NPINS*2-1:0] digits_i,
    output logic [NPINS-1:0]   oe_o,
    output logic [NPINS-1:0]   dat_o
);
    import hdac_pkg::*;

    for (genvar t = 0; t < TERN_PINS; t++) begin : g_tern
        tdig_e dig;
        assign dig = tdig_e'(digits_i[t*2 +: 2]);
        always_comb begin
            case (dig)
                TDIG_HIGH: begin oe_o[t] = 1'b1; dat_o[t] = 1'b1; end
                TDIG_MID:  begin oe_o[t] = 1'b0; dat_o[t] = 1'b0; end
                default:   begin oe_o[t] = 1'b1; dat_o[t] = 1'b0; end
            endcase
        end
    end

    for (genvar b = TERN_PINS; b < NPINS; b++) begin : g_bin
        assign oe_o[b]  = 1'b1;
        assign dat_o[b] = digits_i[b*2] | digits_i[b*2+1];
    end
endmodule

// File: rtl/hdac_ctrl.sv
module hdac_ctrl #(
    parameter int LEVEL_W   = 7,
    parameter int TERN_PINS = 3,
    parameter int BIN_PINS  = 2,
    localparam int NDIG     = TERN_PINS + BIN_PINS,
    localparam int IDX_W    = (NDIG > 1) ? $clog2(NDIG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [LEVEL_W-1:0] sat_level_i,
    input  logic [LEVEL_W-1:0] quot_i,
    input  logic [1:0]         digit_i,
    output logic [LEVEL_W-1:0] rem_o,
    output logic               tern_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [NDIG*2-1:0]  held_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NDIG - 1);
    localparam logic [IDX_W-1:0] TERN_LIM = IDX_W'(TERN_PINS);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [IDX_W-1:0]   idx;
        logic [LEVEL_W-1:0] rem;
        logic [NDIG*2-1:0]  work;
        logic [NDIG*2-1:0]  held;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (load_i) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.rem  = sat_level_i;
                st_d.work = '0;
            end
        end else begin
            st_d.work[st_q.idx*2 +: 2] = digit_i;
            st_d.rem = quot_i;
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.held = st_d.work;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rem_o  = st_q.rem;
    assign tern_o = (st_q.idx < TERN_LIM);
    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign held_o = st_q.held;

    // R8: committed digits only move on completion
    assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.done |-> $stable(st_q.held));

    // R7: a running conversion cannot be abandoned or restarted by load
    assert_busy_ends_in_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> (st_q.busy || st_q.done));

    // R6: done is a single pulse that follows busy
    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> ($past(st_q.busy) && !st_q.busy));
endmodule

// File: rtl/hdac_encoder.sv
module hdac_encoder #(
    parameter int LEVEL_W   = 7,
    parameter int TERN_PINS = 3,
    parameter int BIN_PINS  = 2,
    localparam int NPINS    = TERN_PINS + BIN_PINS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [LEVEL_W-1:0] level_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [NPINS-1:0]   pin_oe_o,
    output logic [NPINS-1:0]   pin_dat_o
);
    logic [LEVEL_W-1:0] sat_level;
    logic [LEVEL_W-1:0] rem;
    logic [LEVEL_W-1:0] quot;
    logic [1:0]         digit;
    logic               tern_sel;
    logic [NPINS*2-1:0] held;

    hdac_clamp #(
        .LEVEL_W  (LEVEL_W),
        .TERN_PINS(TERN_PINS),
        .BIN_PINS (BIN_PINS)
    ) clamp_i (
        .level_i(level_i),
        .level_o(sat_level)
    );

    hdac_digit_div #(
        .LEVEL_W(LEVEL_W)
    ) div_i (
        .rem_i  (rem),
        .tern_i (tern_sel),
        .quot_o (quot),
        .digit_o(digit)
    );

    hdac_ctrl #(
        .LEVEL_W  (LEVEL_W),
        .TERN_PINS(TERN_PINS),
        .BIN_PINS (BIN_PINS)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .sat_level_i(sat_level),
        .quot_i     (quot),
        .digit_i    (digit),
        .rem_o      (rem),
        .tern_o     (tern_sel),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .held_o     (held)
    );

    hdac_pin_map #(
        .TERN_PINS(TERN_PINS),
        .BIN_PINS (BIN_PINS)
    ) map_i (
        .digits_i(held),
        .oe_o    (pin_oe_o),
        .dat_o   (pin_dat_o)
    );

    // R4: binary pins are always driven
    assert_upper_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        &pin_oe_o[NPINS-1:TERN_PINS]);

    // R9: released pins carry a low data value
    assert_released_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (~pin_oe_o & pin_dat_o) == '0);

    // R6: done never lasts two cycles
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/hdac_encoder_tb_top.sv
module hdac_encoder_tb_top;
    localparam int LW = 7;
    localparam int TP = 3;
    localparam int BP = 2;
    localparam int NP = TP + BP;
    localparam int NDIG = NP;
    localparam int LEVELS = 108;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          load;
    logic [LW-1:0] level;
    logic          busy, done;
    logic [NP-1:0] oe, dat;

    hdac_encoder #(.LEVEL_W(LW), .TERN_PINS(TP), .BIN_PINS(BP)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .level_i(level),
        .busy_o(busy), .done_o(done), .pin_oe_o(oe), .pin_dat_o(dat)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    bit          m_busy, m_done;
    int          m_cnt, m_val;
    logic [NP-1:0] m_oe, m_dat;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic encode(input int v, output logic [NP-1:0] e, output logic [NP-1:0] d);
        int r;
        r = v;
        for (int t = 0; t < TP; t++) begin
            case (r % 3)
                0: begin e[t] = 1'b1; d[t] = 1'b0; end
                1: begin e[t] = 1'b0; d[t] = 1'b0; end
                default: begin e[t] = 1'b1; d[t] = 1'b1; end
            endcase
            r = r / 3;
        end
        for (int b = 0; b < BP; b++) begin
            e[TP+b] = 1'b1;
            d[TP+b] = r[0];
            r = r / 2;
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_val = 0;
            m_oe = '1; m_dat = '0;
        end else if (m_busy) begin
            m_cnt++;
            if (m_cnt == NDIG) begin
                m_busy = 0;
                m_done = 1;
                encode(m_val, m_oe, m_dat);
            end else begin
                m_done = 0;
            end
        end else if (load) begin
            m_busy = 1; m_done = 0; m_cnt = 0;
            m_val = (int'(level) >= LEVELS) ? LEVELS - 1 : int'(level);
        end else begin
            m_done = 0;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            check("R6 busy", int'(busy), int'(m_busy));
            check("R6 done", int'(done), int'(m_done));
            check("R2 R3 oe", int'(oe), int'(m_oe));
            check("R2 R3 dat", int'(dat), int'(m_dat));
            check("R4 upper enables", int'(oe[NP-1:TP]), (1 << BP) - 1);
            check("R9 released low", int'(~oe & dat), 0);
        end
        if (cyc > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            summary();
        end
    end

    task automatic convert(input int v);
        @(negedge clk);
        load = 1'b1;
        level = LW'(v);
        @(negedge clk);
        load = 1'b0;
        repeat (NDIG) @(negedge clk);
        check("R6 done at latency", int'(done), 1);
        @(negedge clk);
    endtask

    initial begin
        logic [NP-1:0] e_oe, e_dat, snap_oe, snap_dat;
        rst_n = 1'b0;
        load = 1'b0;
        level = '0;
        repeat (3) @(negedge clk);
        check("R1 reset oe", int'(oe), (1 << NP) - 1);
        check("R1 reset dat", int'(dat), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release oe", int'(oe), (1 << NP) - 1);

        // digit patterns across each radix boundary
        convert(1);
        check("R2 level 1 pin0 released", int'(oe[0]), 0);
        convert(2);
        check("R2 level 2 pin0 high", int'({oe[0], dat[0]}), 3);
        convert(26);
        check("R2 level 26 all ternary high", int'(dat[TP-1:0]), 7);
        convert(27);
        check("R3 level 27 bin pin", int'(dat), 8);
        convert(54);
        check("R3 level 54 bin pin", int'(dat), 16);
        convert(107);
        check("R5 level 107 all high", int'(dat), 31);
        convert(108);
        check("R5 level 108 clamps", int'({oe, dat}), 1023);
        convert(127);
        check("R5 level 127 clamps", int'({oe, dat}), 1023);

        // R7: loads while busy are ignored
        @(negedge clk);
        load = 1'b1; level = 7'd5;
        @(negedge clk);
        level = 7'd100;
        repeat (3) @(negedge clk);
        load = 1'b0;
        repeat (NDIG - 3) @(negedge clk);
        encode(5, e_oe, e_dat);
        check("R7 kept first level oe", int'(oe), int'(e_oe));
        check("R7 kept first level dat", int'(dat), int'(e_dat));
        repeat (3) begin
            @(negedge clk);
            check("R7 no later conversion", int'(busy), 0);
        end

        // R8: pins hold while idle
        snap_oe = oe; snap_dat = dat;
        @(negedge clk);
        level = 7'd80;
        repeat (6) @(negedge clk);
        check("R8 idle hold oe", int'(oe), int'(snap_oe));
        check("R8 idle hold dat", int'(dat), int'(snap_dat));

        // sweep of all codes
        for (int v = 0; v < 128; v++) convert(v);

        // load held high with changing level
        @(negedge clk);
        load = 1'b1;
        for (int k = 0; k < 80; k++) begin
            level = LW'((k * 37) % 128);
            @(negedge clk);
        end
        load = 1'b0;
        repeat (NDIG + 3) @(negedge clk);
        convert(0);
        check("R2 level 0 all low", int'({oe, dat}), 992);

        summary();
    end
endmodule